// File: doc/BRIEF.md
# Half-Step Programmable Clock Divider

This block turns a fast input clock into a master clock enable whose rate is the input rate divided by a ratio that can be set in steps of one half. A 6-bit ratio code `a` selects a divide ratio of `(a/2)+1`. Code 0 divides by 1.0, code 1 by 1.5, code 6 by 4, code 62 by 32.0 and code 63 by 32.5. With a nominal 48 MHz input, code 0 gives a 48 MHz master rate and code 63 gives about 1.48 MHz. A second enable runs at one eighth of the master rate and paces a converter.

Both outputs are one-input-cycle-wide enable pulses, synchronous to the input clock. They are not derived clocks. Downstream logic stays on the fast clock and qualifies its registers with them. A ratio of the form N.5 cannot be met by equal periods. The block therefore alternates between a short period of N input cycles and a long period of N+1 input cycles, so that the average spacing is exact over every pair of periods. A new ratio code is taken only at the input edge that closes a master period. A change therefore never shortens or stretches the period in progress and never makes a runt pulse.

Top module: `halfstep_clkdiv`

## Requirements
- R1: While `rst` is high, `mclkEn` and `adcEn` are low. Reset leaves code 0 in force, so `mclkEn` is high in the first input cycle after `rst` falls and in every cycle after that until another code is loaded.
- R2: For an even code `a`, `mclkEn` is a single-cycle pulse repeating every `a/2+1` input cycles.
- R3: For an odd code `a`, the spacing between successive `mclkEn` pulses alternates between `(a+1)/2` (short) and `(a+3)/2` (long) input cycles. The first period after a change to a different code is the short one.
- R4: At the ends of the range, code 1 gives spacings 1,2,1,2…, code 62 gives 32, and code 63 gives 32,33,32,33…. No two consecutive `mclkEn` pulses are ever more than 33 input cycles apart.
- R5: `ratioCode` is sampled only at the rising edge of `clk` at which `mclkEn` is high. Any value it holds at other edges has no effect on the pulse spacing.
- R6: `adcEn` is high only in cycles where `mclkEn` is high. It is high on every eighth `mclkEn` pulse, counting from the first pulse after reset. The count runs on unchanged across code changes.
- R7: Loading the same odd code again at a period end continues the short/long alternation where it stood; it does not restart it with a short period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| ratioCode | input | 6 | Divide ratio code `a`, ratio = `(a/2)+1` |
| mclkEn | output | 1 | Master clock enable, one input cycle wide |
| adcEn | output | 1 | Converter enable, every eighth master enable |

## Verification
Two situations are hard to reach from the ports. One is a ratio code that changes in the middle of a master period and is put back before the period closes. The other is an odd code written twice in a row. Both depend on where the block is within its period and its short/long alternation, and the ports do not show that position. The stimulus therefore follows `mclkEn`. Each new code is placed in the low phase of the clock right after an observed master pulse, so it is loaded at that pulse's closing edge. For the mid-period case, a different value is driven for one cycle well inside an 11-cycle period and then removed. The bench keeps its own record of the alternation phase. From that record it predicts whether a repeated odd code must continue with a long period.

// File: rtl/hsdiv_pkg.sv
package hsdiv_pkg;

  // Strobes from the period sequencer to the datapath
  typedef struct packed {
    logic periodEnd;   // last input cycle of the current master period
  } divStrobe_t;

endpackage

// File: rtl/hsdiv_ctrl.sv
module hsdiv_ctrl
  import hsdiv_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] periodLen,
  output divStrobe_t       strobe
);

  // Position inside the current master period, runs 1..periodLen
  logic [CNT_W-1:0] cycleCnt;
  logic             atEnd;

  assign atEnd = (cycleCnt >= periodLen);

  always_ff @(posedge clk) begin
    if (rst) begin
      cycleCnt <= CNT_W'(1);
    end else if (atEnd) begin
      cycleCnt <= CNT_W'(1);
    end else begin
      cycleCnt <= cycleCnt + CNT_W'(1);
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.periodEnd = atEnd & ~rst;
  end

endmodule

// File: rtl/hsdiv_datapath.sv
module hsdiv_datapath
  import hsdiv_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int CNT_W   = CODE_W,
  parameter int ADC_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratioCode,
  input  divStrobe_t        strobe,
  output logic [CNT_W-1:0]  periodLen,
  output logic              mclkEn,
  output logic              adcEn
);

  localparam int HALF_W = CODE_W - 1;

  logic [CODE_W-1:0] activeCode;
  logic              longPhase;
  logic [HALF_W-1:0] halfCode;
  logic              isOdd;

  // Code in force and short/long phase; both change only at a period end
  always_ff @(posedge clk) begin
    if (rst) begin
      activeCode <= '0;
      longPhase  <= 1'b0;
    end else if (strobe.periodEnd) begin
      activeCode <= ratioCode;
      longPhase  <= (ratioCode != activeCode) ? 1'b0 : ~longPhase;
    end
  end

  // Even a: a/2+1. Odd a: short (a+1)/2 = a>>1 + 1, long (a+3)/2 = a>>1 + 2
  assign halfCode = activeCode[CODE_W-1:1];
  assign isOdd    = activeCode[0];

  always_comb begin
    if (isOdd && longPhase) begin
      periodLen = CNT_W'({1'b0, halfCode}) + CNT_W'(2);
    end else begin
      periodLen = CNT_W'({1'b0, halfCode}) + CNT_W'(1);
    end
  end

  assign mclkEn = strobe.periodEnd;

  // Converter enable: every ADC_DIV-th master pulse
  generate
    if (ADC_DIV > 1) begin : g_adcDiv
      localparam int ADC_W = $clog2(ADC_DIV);
      logic [ADC_W-1:0] adcCnt;
      logic             adcWrap;

      assign adcWrap = (adcCnt == ADC_W'(ADC_DIV - 1));

      always_ff @(posedge clk) begin
        if (rst) begin
          adcCnt <= '0;
        end else if (strobe.periodEnd) begin
          adcCnt <= adcWrap ? '0 : adcCnt + ADC_W'(1);
        end
      end

      assign adcEn = strobe.periodEnd & adcWrap;
    end else begin : g_adcPass
      assign adcEn = strobe.periodEnd;
    end
  endgenerate

endmodule

// File: rtl/halfstep_clkdiv.sv
module halfstep_clkdiv
  import hsdiv_pkg::*;
#(
  parameter int CODE_W  = 6,
  parameter int ADC_DIV = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] ratioCode,
  output logic              mclkEn,
  output logic              adcEn
);

  localparam int CNT_W = CODE_W;

  divStrobe_t       strobe;
  logic [CNT_W-1:0] periodLen;

  hsdiv_ctrl #(
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .periodLen (periodLen),
    .strobe    (strobe)
  );

  hsdiv_datapath #(
    .CODE_W  (CODE_W),
    .CNT_W   (CNT_W),
    .ADC_DIV (ADC_DIV)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ratioCode (ratioCode),
    .strobe    (strobe),
    .periodLen (periodLen),
    .mclkEn    (mclkEn),
    .adcEn     (adcEn)
  );

endmodule

// File: rtl/halfstep_clkdiv_chk.sv
module halfstep_clkdiv_chk #(
  parameter int CODE_W  = 6,
  parameter int ADC_DIV = 8
) (
  input logic clk,
  input logic rst,
  input logic mclkEn,
  input logic adcEn
);

  localparam int MAX_PERIOD = (1 << (CODE_W - 1)) + 1;
  localparam int IDLE_W     = $clog2(MAX_PERIOD) + 1;
  localparam int PCNT_W     = $clog2(ADC_DIV + 1);

  logic [IDLE_W-1:0] idleRun;
  logic [PCNT_W-1:0] pulsesSinceAdc;

  always_ff @(posedge clk) begin
    if (rst) begin
      idleRun <= '0;
    end else if (mclkEn) begin
      idleRun <= '0;
    end else if (idleRun != '1) begin
      idleRun <= idleRun + IDLE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulsesSinceAdc <= '0;
    end else if (mclkEn) begin
      pulsesSinceAdc <= adcEn ? '0 : pulsesSinceAdc + PCNT_W'(1);
    end
  end

  AST_FIRST_PULSE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> mclkEn); // R1

  AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (rst)
    idleRun <= IDLE_W'(MAX_PERIOD - 1)); // R4

  AST_ADC_INSIDE_MCLK: assert property (@(posedge clk) disable iff (rst)
    adcEn |-> mclkEn); // R6

  AST_ADC_SPACING: assert property (@(posedge clk) disable iff (rst)
    adcEn |-> (pulsesSinceAdc == PCNT_W'(ADC_DIV - 1))); // R6

  AST_ADC_NOT_MISSED: assert property (@(posedge clk) disable iff (rst)
    (mclkEn && (pulsesSinceAdc == PCNT_W'(ADC_DIV - 1))) |-> adcEn); // R6

endmodule

bind halfstep_clkdiv halfstep_clkdiv_chk #(
  .CODE_W  (CODE_W),
  .ADC_DIV (ADC_DIV)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mclkEn (mclkEn),
  .adcEn  (adcEn)
);

// File: tb/test_halfstep_clkdiv.sv
`timescale 1ns/1ps
module test_halfstep_clkdiv;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] ratioCode = 6'd0;
  logic       mclkEn;
  logic       adcEn;

  int checks = 0;
  int errors = 0;

  int    expQ[$];
  string tagQ[$];

  int lastCode = 0;
  bit nextLong = 1'b1;   // reset period plus first pulse already toggled once

  halfstep_clkdiv i_halfstep_clkdiv (
    .clk       (clk),
    .rst       (rst),
    .ratioCode (ratioCode),
    .mclkEn    (mclkEn),
    .adcEn     (adcEn)
  );

  always #2.5 clk = ~clk;

  function automatic int periodFor(int code, bit lng);
    if (code % 2 == 0) return code / 2 + 1;
    return lng ? (code + 3) / 2 : (code + 1) / 2;
  endfunction

  task automatic check(bit ok, string req, int act, int exp, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Driver: called at a negedge where mclkEn is high; the code goes in at the
  // closing edge of that pulse. Optional junk value is shown for one cycle mid-period.
  task automatic runCode(int code, int n, string tag, int junk);
    if (code != lastCode) nextLong = 1'b0;
    lastCode  = code;
    ratioCode = 6'(code);
    #1;
    for (int i = 0; i < n; i++) begin
      expQ.push_back(periodFor(code, nextLong));
      tagQ.push_back(tag);
      nextLong = ~nextLong;
    end
    if (junk >= 0) begin
      @(negedge clk) ratioCode = 6'(junk);
      @(negedge clk) ratioCode = 6'(code);
    end
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!mclkEn);
    end
  endtask

  // Monitor: measures pulse spacing and converter cadence
  int cyc = 0;
  int lastPulse = 0;
  bit havePrev = 1'b0;
  int pulseNum = 0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; havePrev = 1'b0; pulseNum = 0;
    end else begin
      cyc++;
      if (mclkEn) begin
        pulseNum++;
        if (havePrev && expQ.size() > 0) begin
          int e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check((cyc - lastPulse) == e, t, cyc - lastPulse, e, "pulse spacing");
        end
        lastPulse = cyc;
        havePrev  = 1'b1;
        check(adcEn == (pulseNum % 8 == 0), "R6", int'(adcEn),
              int'(pulseNum % 8 == 0), "adcEn on master pulse");
      end else if (adcEn) begin
        check(1'b0, "R6", 1, 0, "adcEn without mclkEn");
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) begin
      @(negedge clk);
      check(!mclkEn && !adcEn, "R1", int'(mclkEn) + int'(adcEn), 0, "outputs in reset");
    end
    @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(mclkEn == 1'b1, "R1", int'(mclkEn), 1, "first cycle after reset");

    runCode(0, 6, "R1", -1);      // input rate
    runCode(6, 5, "R2", -1);      // divide by 4
    runCode(9, 6, "R3", -1);      // 5,6 alternation
    runCode(5, 3, "R3", -1);      // 3,4,3
    runCode(5, 4, "R7", -1);      // continues with 4
    runCode(1, 6, "R4", -1);      // 1,2
    runCode(62, 3, "R4", -1);     // 32
    runCode(63, 4, "R4", -1);     // 32,33
    runCode(20, 3, "R5", 3);      // 11, mid-period junk ignored
    runCode(2, 4, "R2", -1);      // 2
    runCode(0, 20, "R6", -1);     // more converter pulses

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R2", expQ.size(), 0, "pending expected pulses");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule